// File: doc/BRIEF.md
# Bitwise Three-Input Ternary Logic Unit

This unit evaluates an arbitrary three-input Boolean function on every bit lane of three 64-bit operands at once. The function comes as an 8-bit truth table taken from an instruction immediate. Each lane is independent. Lane i forms a 3-bit index from bit i of each operand, and the result bit is the table entry at that index. A 2-bit carry field goes out with every result and is always zero.

Operands and table enter on a valid/ready stream, and results leave on another. A single register stage sits between the two streams. An item accepted on an input handshake shows up as valid on the output in the next cycle. The output holds its data, unchanged, for as long as the consumer keeps ready low. The input is ready whenever the stage is empty, or whenever its current item leaves in the same cycle. This gives full throughput when the consumer never stalls. Items leave in the order they were accepted.

Top module: `ternlog_unit`

## Requirements
- R1: For every lane i, out_result[i] equals in_table[idx], where idx is the 3-bit index of that lane.
- R2: The index of lane i is {in_c[i], in_a[i], in_b[i]}: in_b supplies index bit 0, in_a supplies index bit 1 and in_c supplies index bit 2. For example, table 0x02 yields b&~a&~c, 0x04 yields a&~b&~c and 0x10 yields c&~a&~b.
- R3: A table of 0x00 gives an all-zero result and 0xFF gives an all-ones result, whatever the operands. Standard tables give their usual functions: 0x96 is a^b^c, 0xE8 is the majority of a, b and c, and 0xCA is (c ? a : b).
- R4: out_carry is 2'b00 for every result.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_result stays unchanged.
- R6: An item accepted when in_valid and in_ready are both high at a clock edge is presented with out_valid high in the following cycle. in_ready is high whenever the stage is empty or its item is being taken in that cycle.
- R7: After reset, out_valid is low and in_ready is high.
- R8: Results leave in the same order as their items were accepted, and none is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can take an input item |
| in_a | input | 64 | Operand A, index bit 1 |
| in_b | input | 64 | Operand B, index bit 0 |
| in_c | input | 64 | Operand C, index bit 2 |
| in_table | input | 8 | Truth table immediate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Per-lane function result |
| out_carry | output | 2 | Carry field, always zero |

## Verification
The only internal state is the occupancy flag and the held result. A wrong index ordering or a wrong table bit shows up as a bad result on the very next output handshake, for the table patterns that single out each operand. A stale or lost occupancy flag shows up as a missing, repeated or reordered result, or as a result that changes during a stall. The scoreboard reports such a fault within one or two cycles of the affected handshake.

// File: rtl/ternlog_pkg.sv
package ternlog_pkg;
  localparam int unsigned TBL_W   = 8;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned CARRY_W = 2;
  typedef logic [TBL_W-1:0]   tbl_t;
  typedef logic [CARRY_W-1:0] carry_t;
endpackage

// File: rtl/tl_lane_lut.sv
module tl_lane_lut
  import ternlog_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] opc,
  input  tbl_t             tbl,
  output logic [WIDTH-1:0] res
);
  // one table lookup per lane; index = {c, a, b}
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic [IDX_W-1:0] sel;
    assign sel    = {opc[i], opa[i], opb[i]};
    assign res[i] = tbl[sel];
  end
endmodule

// File: rtl/tl_hold_stage.sv
module tl_hold_stage #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  logic          full_q;
  logic [DW-1:0] data_q;

  assign s_ready = !full_q || m_ready;
  assign m_valid = full_q;
  assign m_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (s_ready) begin
      full_q <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) begin
      data_q <= s_data;
    end
  end
endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import ternlog_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  input  logic [7:0]       in_table,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic [1:0]       out_carry
);
  logic [WIDTH-1:0] lane_res;

  tl_lane_lut #(.WIDTH(WIDTH)) u_lut (
    .opa(in_a),
    .opb(in_b),
    .opc(in_c),
    .tbl(in_table),
    .res(lane_res)
  );

  tl_hold_stage #(.DW(WIDTH)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (lane_res),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (out_result)
  );

  assign out_carry = '0;
endmodule

// File: rtl/ternlog_unit_chk.sv
module ternlog_unit_chk #(
  parameter int unsigned WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic [WIDTH-1:0] in_c,
  input logic [7:0]       in_table,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic [1:0]       out_carry
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R4
  carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_carry == 2'b00));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R6
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R3
  table_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_table == 8'h00) |=> (out_result == '0));

  // R3
  table_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_table == 8'hFF) |=> (out_result == '1));

  // R2
  lane0_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_result[0] == $past(in_table[{in_c[0], in_a[0], in_b[0]}])));

  // R6
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind ternlog_unit ternlog_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_table(in_table),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_carry(out_carry)
);

// File: tb/ternlog_unit_bench.sv
module ternlog_unit_bench;
  localparam int W = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0, out_result;
  logic [7:0] in_table = '0;
  logic [1:0] out_carry;

  int total = 0, bad = 0, cycles = 0;
  bit rand_ready = 1'b0;
  bit finished = 1'b0;

  typedef struct { logic [W-1:0] res; string req; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ternlog_unit #(.WIDTH(W)) u_ternlog_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_table(in_table),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_carry(out_carry)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lut_model(input logic [W-1:0] a, b, c, input logic [7:0] t);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = t[{c[i], a[i], b[i]}];
    return r;
  endfunction

  task automatic send(input logic [W-1:0] a, b, c, input logic [7:0] t,
                      input logic [W-1:0] exp, input string req);
    item_t it;
    in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_table = t;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    it.res = exp; it.req = req;
    sb.push_back(it);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    // R6: one-cycle latency to out_valid
    check(out_valid === 1'b1, "R6", {63'd0, out_valid}, 64'd1);
    @(posedge clk); #1;
  endtask

  // consumer ready pattern
  always @(posedge clk) begin
    #1;
    if (rand_ready) out_ready <= ($urandom % 3) != 0;
    else out_ready <= 1'b1;
  end

  // monitor / scoreboard
  bit prev_stall = 1'b0;
  logic [W-1:0] prev_res;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid === 1'b1 && out_result === prev_res, "R5", out_result, prev_res);
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", out_result, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(out_result === it.res, it.req, out_result, it.res);
          check(out_carry === 2'b00, "R4", {62'd0, out_carry}, 64'd0);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res   = out_result;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, c;
    logic [7:0] t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7
    check(out_valid === 1'b0, "R7", {63'd0, out_valid}, 64'd0);
    check(in_ready === 1'b1, "R7", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    a = 64'hF0F0_CCCC_AAAA_0123; b = 64'hFF00_F0F0_3333_4567; c = 64'hFFFF_0000_5A5A_89AB;
    // R2: single-entry tables isolate each operand
    send(a, b, c, 8'h02, b & ~a & ~c, "R2");
    send(a, b, c, 8'h04, a & ~b & ~c, "R2");
    send(a, b, c, 8'h10, c & ~a & ~b, "R2");
    // R3: constant and standard tables
    send(a, b, c, 8'h00, '0, "R3");
    send(a, b, c, 8'hFF, '1, "R3");
    send(a, b, c, 8'h96, a ^ b ^ c, "R3");
    send(a, b, c, 8'hE8, (a & b) | (a & c) | (b & c), "R3");
    send(a, b, c, 8'hCA, (c & a) | (~c & b), "R3");
    // R1: random tables and operands
    for (int k = 0; k < 20; k++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
      t = 8'($urandom);
      send(a, b, c, t, lut_model(a, b, c, t), "R1");
    end
    // R5/R8: stalling consumer, order kept
    rand_ready = 1'b1;
    for (int k = 0; k < 30; k++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
      t = 8'($urandom);
      in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_table = t;
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      begin
        item_t it;
        it.res = lut_model(a, b, c, t); it.req = "R8";
        sb.push_back(it);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
    rand_ready = 1'b0;
    while (sb.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R8: nothing extra emitted
    check(out_valid === 1'b0, "R8", {63'd0, out_valid}, 64'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule